// File: doc/BRIEF.md
# Four-Channel Lockstep Serial Sample Capture

This block reads four external 24-bit converters together. It generates one serial clock from a programmable divider of the system clock and sends that clock to all four converters. One command output line is shared by the four converters, so a configuration word reaches all of them at the same time. The four serial data returns are not sampled with the local clock. They are sampled with a copy of the serial clock that comes back through the external link, so the link delay (for example across an isolation barrier) does not shift the sampling point.

A capture frame is exactly 24 clock periods long and produces one signed sample per channel. Each sample is sign-extended to a 32-bit word. The four words are written in channel order to a simple memory write port, at consecutive addresses starting from a base address. When a programmed number of sample sets has been stored, an interrupt is raised. The interrupt stays high until it is cleared, and clearing it sends the write pointer back to the base. A frame starts on a start pulse or while the data-ready input is held low.

Top module: `quad_adc_capture`

## Requirements
- R1: After reset, sclk_o, mosi_o, busy_o, mem_we_o and irq_o are all 0.
- R2: Each frame has exactly 24 sclk_o rising edges. Each high phase and each low phase lasts clk_div_i system cycles (clk_div_i >= 2). sclk_o is low whenever busy_o is 0.
- R3: A frame starts only when the block is idle and one of these holds: start_i is pulsed, drdy_n_i is low, or cfg_wr_i is pulsed. With none of these, busy_o stays 0 and nothing is written.
- R4: The four miso_i lines are shifted in together, MSB first. Each bit is taken on a falling edge of the returned clock rsclk_i. miso_i bit c belongs to channel c.
- R5: Each stored word is the 24-bit sample in bits 23:0, with bit 23 copied into bits 31:24.
- R6: After each capture frame, four writes follow on consecutive cycles, for channels 0, 1, 2, 3, at addresses base_addr_i + 4k + c. Here k is the index of the sample set since the last clear.
- R7: irq_o rises right after the write that completes buf_len_i sample sets. It stays 1 until irq_clr_i. While it is 1, start_i and drdy_n_i start no frame and no write happens.
- R8: A one-cycle irq_clr_i pulse drops irq_o. The next sample set is written from base_addr_i again.
- R9: A cfg_wr_i frame shifts cfg_word_i out on mosi_o MSB first. Each bit is valid at a sclk_o rising edge. The frame performs no memory write and ignores miso_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div_i | input | DIV_W | Half period of sclk_o in system cycles |
| base_addr_i | input | ADDR_W | First buffer word address |
| buf_len_i | input | LEN_W | Sample sets per buffer before the interrupt |
| start_i | input | 1 | Start one capture frame |
| drdy_n_i | input | 1 | Active-low data ready, starts frames while low |
| cfg_wr_i | input | 1 | Start one command frame |
| cfg_word_i | input | 24 | Command word to shift out |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt |
| rsclk_i | input | 1 | Returned copy of sclk_o |
| miso_i | input | NCH | Serial data from the converters |
| sclk_o | output | 1 | Serial clock to the converters |
| mosi_o | output | 1 | Shared command line |
| busy_o | output | 1 | A frame or its store is in progress |
| mem_we_o | output | 1 | Buffer write enable |
| mem_addr_o | output | ADDR_W | Buffer word address |
| mem_wdata_o | output | WORD_W | Buffer write data |
| irq_o | output | 1 | Buffer-full interrupt |

## Verification
The assertions assume a few things about the inputs:
- clk_div_i is at least 2 and stays fixed during a frame.
- The returned clock lags sclk_o by less than one system cycle.
- The converters change miso_i only right after a returned-clock rising edge.
- buf_len_i is at least 1.

The bench meets these assumptions. It models the link as a fixed 3 ns delay from sclk_o to rsclk_i. Its converter model drives each new bit on the delayed rising edge. It changes the divider only while the block is idle.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RXWAIT,
    ST_STORE
  } qsc_state_e;

  localparam int FRAME_BITS = 24;
endpackage

// File: rtl/qsc_sclk_gen.sv
module qsc_sclk_gen #(
  parameter int DIV_W = 8,
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall,
  output logic             done
);
  localparam int CW = $clog2(NBITS + 1);

  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [CW-1:0]    nfall;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      sclk   <= 1'b0;
      nfall  <= '0;
      fall   <= 1'b0;
      done   <= 1'b0;
    end else begin
      fall <= 1'b0;
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        cnt    <= '0;
        sclk   <= 1'b0;
        nfall  <= '0;
      end else if (active) begin
        if (cnt == div - DIV_W'(1)) begin
          cnt  <= '0;
          sclk <= ~sclk;
          if (sclk) begin
            fall <= 1'b1;
            if (nfall == CW'(NBITS - 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
              nfall  <= '0;
            end else begin
              nfall <= nfall + CW'(1);
            end
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qsc_deser.sv
module qsc_deser #(
  parameter int NCH      = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clr,
  input  logic                             en,
  input  logic                             rsclk,
  input  logic [NCH-1:0]                   miso,
  output logic [NCH-1:0][SAMPLE_W-1:0]     data,
  output logic                             done
);
  localparam int CW = $clog2(SAMPLE_W + 1);

  logic [2:0]     rs_sync;
  logic [NCH-1:0] m1, m2;
  logic [CW-1:0]  nbit;
  logic           take;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_sync <= '0;
      m1      <= '0;
      m2      <= '0;
    end else begin
      rs_sync <= {rs_sync[1:0], rsclk};
      m1      <= miso;
      m2      <= m1;
    end
  end

  assign take = en && rs_sync[2] && !rs_sync[1];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          data[c] <= '0;
        end else if (take) begin
          data[c] <= {data[c][SAMPLE_W-2:0], m2[c]};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nbit <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        nbit <= '0;
      end else if (take) begin
        if (nbit == CW'(SAMPLE_W - 1)) begin
          nbit <= '0;
          done <= 1'b1;
        end else begin
          nbit <= nbit + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qsc_writer.sv
module qsc_writer #(
  parameter int NCH      = 4,
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 10,
  parameter int LEN_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         take,
  input  logic [NCH-1:0][SAMPLE_W-1:0] samples,
  input  logic [ADDR_W-1:0]            base,
  input  logic [LEN_W-1:0]             len,
  input  logic                         clr,
  output logic                         we,
  output logic [ADDR_W-1:0]            addr,
  output logic [WORD_W-1:0]            wdata,
  output logic                         irq,
  output logic                         done
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0][SAMPLE_W-1:0] hold;
  logic                         active;
  logic [IW-1:0]                idx;
  logic [ADDR_W-1:0]            off;
  logic [LEN_W-1:0]             sets;
  logic [SAMPLE_W-1:0]          cur;

  assign cur = hold[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      active <= 1'b0;
      idx    <= '0;
      off    <= '0;
      sets   <= '0;
      we     <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      irq    <= 1'b0;
      done   <= 1'b0;
    end else begin
      we   <= 1'b0;
      done <= 1'b0;
      if (clr) begin
        irq  <= 1'b0;
        off  <= '0;
        sets <= '0;
      end else if (take && !active) begin
        hold   <= samples;
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        we    <= 1'b1;
        addr  <= base + off;
        wdata <= {{(WORD_W-SAMPLE_W){cur[SAMPLE_W-1]}}, cur};
        off   <= off + ADDR_W'(1);
        if (idx == IW'(NCH - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          sets   <= sets + LEN_W'(1);
          if (sets + LEN_W'(1) == len) irq <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/quad_adc_capture.sv
module quad_adc_capture
  import qsc_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SAMPLE_W = FRAME_BITS,
  parameter int WORD_W   = 32,
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [LEN_W-1:0]    buf_len_i,
  input  logic                start_i,
  input  logic                drdy_n_i,
  input  logic                cfg_wr_i,
  input  logic [SAMPLE_W-1:0] cfg_word_i,
  input  logic                irq_clr_i,
  input  logic                rsclk_i,
  input  logic [NCH-1:0]      miso_i,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                busy_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic                irq_o
);
  qsc_state_e state;
  logic       cfg_mode;
  logic       go, go_cfg;
  logic       gen_fall, gen_done;
  logic       rx_done, wr_done;
  logic [SAMPLE_W-1:0] cmd_sr;
  logic [NCH-1:0][SAMPLE_W-1:0] rx_data;

  assign go_cfg = (state == ST_IDLE) && cfg_wr_i;
  assign go     = (state == ST_IDLE) && (cfg_wr_i || (!irq_o && (start_i || !drdy_n_i)));
  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cfg_mode <= 1'b0;
      cmd_sr   <= '0;
      mosi_o   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state    <= ST_SHIFT;
          cfg_mode <= go_cfg;
          if (go_cfg) begin
            mosi_o <= cfg_word_i[SAMPLE_W-1];
            cmd_sr <= {cfg_word_i[SAMPLE_W-2:0], 1'b0};
          end
        end
        ST_SHIFT: begin
          if (gen_done) begin
            mosi_o <= 1'b0;
            state  <= cfg_mode ? ST_IDLE : ST_RXWAIT;
          end else if (gen_fall && cfg_mode) begin
            mosi_o <= cmd_sr[SAMPLE_W-1];
            cmd_sr <= {cmd_sr[SAMPLE_W-2:0], 1'b0};
          end
        end
        ST_RXWAIT: if (rx_done) state <= ST_STORE;
        ST_STORE:  if (wr_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  qsc_sclk_gen #(.DIV_W(DIV_W), .NBITS(SAMPLE_W)) u_gen (
    .clk(clk), .rst(rst), .go(go), .div(clk_div_i),
    .sclk(sclk_o), .fall(gen_fall), .done(gen_done)
  );

  qsc_deser #(.NCH(NCH), .SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst(rst), .clr(go),
    .en(!cfg_mode && (state == ST_SHIFT || state == ST_RXWAIT)),
    .rsclk(rsclk_i), .miso(miso_i), .data(rx_data), .done(rx_done)
  );

  qsc_writer #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W),
               .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst(rst), .take(rx_done && state == ST_RXWAIT),
    .samples(rx_data), .base(base_addr_i), .len(buf_len_i), .clr(irq_clr_i),
    .we(mem_we_o), .addr(mem_addr_o), .wdata(mem_wdata_o),
    .irq(irq_o), .done(wr_done)
  );
endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int ADDR_W   = 10,
  parameter int WORD_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              irq_clr_i,
  input logic              sclk_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              irq_o
);
  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o);

  // R3
  start_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !irq_o && start_i) |=> busy_o);

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wdata_o[WORD_W-1:SAMPLE_W] == {(WORD_W-SAMPLE_W){mem_wdata_o[SAMPLE_W-1]}}));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R7
  no_store_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o)) |-> !mem_we_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_clr_i |=> !irq_o);
endmodule

bind quad_adc_capture qsc_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .irq_clr_i(irq_clr_i),
  .sclk_o(sclk_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .irq_o(irq_o)
);

// File: tb/tb_quad_adc_capture.sv
`timescale 1ns/1ps
module tb_quad_adc_capture;
  localparam int AW = 10;

  logic clk = 0, rst = 1;
  logic [7:0] clk_div = 8'd2;
  logic [AW-1:0] base = 10'h100;
  logic [7:0] blen = 8'd3;
  logic start = 0, drdy_n = 1, cfg_wr = 0, irq_clr = 0;
  logic [23:0] cfg_word = '0;
  logic rsclk = 0;
  logic [3:0] miso = '0;
  logic sclk, mosi, busy, we, irq;
  logic [AW-1:0] addr;
  logic [31:0] wdata;

  int checks = 0, errors = 0, nwr = 0, sclk_cnt = 0, adc_idx = 0;
  time t_rise = 0, hp = 0;
  logic [23:0] adc_val [4];
  logic [23:0] mosi_sr = '0;
  logic [AW+31:0] q[$];
  int ex_off = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  quad_adc_capture dut (
    .clk(clk), .rst(rst), .clk_div_i(clk_div), .base_addr_i(base),
    .buf_len_i(blen), .start_i(start), .drdy_n_i(drdy_n), .cfg_wr_i(cfg_wr),
    .cfg_word_i(cfg_word), .irq_clr_i(irq_clr), .rsclk_i(rsclk), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .busy_o(busy), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .irq_o(irq)
  );

  always @(sclk) rsclk <= #3 sclk;

  always @(posedge rsclk) begin
    if (adc_idx < 24) begin
      for (int c = 0; c < 4; c++) miso[c] <= adc_val[c][23-adc_idx];
      adc_idx <= adc_idx + 1;
    end
  end

  always @(posedge sclk) begin
    sclk_cnt <= sclk_cnt + 1;
    t_rise = $time;
    mosi_sr <= {mosi_sr[22:0], mosi};
  end
  always @(negedge sclk) hp = $time - t_rise;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every buffer write
  always @(negedge clk) begin
    if (we && !rst) begin
      nwr++;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R6 actual=%0h expected=none", {addr, wdata});
      end else begin
        logic [AW+31:0] e;
        e = q.pop_front();
        if (e != {addr, wdata}) begin
          errors++;
          $display("FAIL R4/R5/R6 actual=%0h expected=%0h", {addr, wdata}, e);
        end
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Driver: loads the converter model and pushes expected words
  task automatic frame(input logic [23:0] v0, v1, v2, v3, input bit use_drdy);
    adc_val[0] = v0; adc_val[1] = v1; adc_val[2] = v2; adc_val[3] = v3;
    for (int c = 0; c < 4; c++)
      q.push_back({base + AW'(ex_off + c), {{8{adc_val[c][23]}}, adc_val[c]}});
    ex_off += 4;
    adc_idx = 0; sclk_cnt = 0;
    @(negedge clk);
    if (use_drdy) drdy_n = 0; else start = 1;
    @(negedge clk);
    drdy_n = 1; start = 0;
    wait_idle();
    chk(sclk_cnt == 24, "R2 edge count", sclk_cnt, 24);
    chk(hp == clk_div * 4, "R2 half period", hp, clk_div * 4);
  endtask

  initial begin
    #800000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk({sclk, mosi, busy, we, irq} == 5'b0, "R1 reset outputs", {sclk, mosi, busy, we, irq}, 0);

    // R3: no trigger, nothing happens
    repeat (30) @(negedge clk);
    chk(busy == 0, "R3 no trigger busy", busy, 0);
    chk(nwr == 0, "R3 no trigger writes", nwr, 0);

    // R4 R5 R6: distinct patterns
    frame(24'h123456, 24'h00ABCD, 24'h7FFFFF, 24'h000001, 0);
    frame(24'h800000, 24'hFFFFFF, 24'hA5A5A5, 24'h5A5A5A, 0);
    chk(irq == 0, "R7 no early irq", irq, 0);
    // R3: data-ready held low starts a frame
    frame(24'hC00003, 24'h3C3C3C, 24'h0F0F0F, 24'hF0F0F0, 1);
    chk(irq == 1, "R7 irq after len", irq, 1);

    // R7: triggers ignored while irq pending
    w0 = nwr;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(busy == 0, "R7 blocked busy", busy, 0);
    chk(nwr == w0, "R7 blocked writes", nwr, w0);
    chk(irq == 1, "R7 irq holds", irq, 1);

    // R8: clear and rewind
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R8 irq cleared", irq, 0);
    ex_off = 0;
    clk_div = 8'd5;
    frame(24'h654321, 24'h876543, 24'h000000, 24'hFEDCBA, 0);

    // R9: configuration frame
    w0 = nwr;
    cfg_word = 24'hA5C33C;
    sclk_cnt = 0;
    @(negedge clk); cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    wait_idle();
    chk(mosi_sr == cfg_word, "R9 command bits", mosi_sr, cfg_word);
    chk(nwr == w0, "R9 no writes", nwr, w0);
    chk(sclk_cnt == 24, "R2 cfg edge count", sclk_cnt, 24);
    chk(q.size() == 0, "R6 all words seen", q.size(), 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule